// File: doc/BRIEF.md
# Write-Completion Acknowledge Poller

This block is a master-side sequencer that runs above a byte-level two-wire bus engine. It is used after the master has closed a memory write with a stop condition. From then on the target is busy with its internally timed write and refuses to acknowledge its own address. The poller starts probing immediately, with no fixed wait. Each probe is a start condition followed by the control byte, which is the 7-bit device address with the direction bit cleared. A refused probe is closed with a stop and then repeated.

When a probe is acknowledged, the poller raises `ready` and returns control with the bus still addressed. The next command can then continue the open transaction or close it with its own stop. If `MAX_PROBES` probes are all refused, it raises `timeout_err` instead. It drives the engine one command at a time: a one-cycle `cmd_valid` with an operation code, then a wait for the engine's `eng_done` pulse.

Top module: `ack_poll_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `busy`, `ready`, `timeout_err` and `cmd_valid` are 0 and `probe_count` is 0.
- R2: Every probe issues a start (`cmd_op` = 2'b01) and then a byte send (`cmd_op` = 2'b10). The byte send carries `cmd_byte` = {device address, 1'b0}, with the direction bit at bit 0.
- R3: `cmd_valid` lasts exactly one cycle. No new command is issued before the engine has answered the previous one with `eng_done`.
- R4: When the engine reports `eng_nack` = 1 for a probe byte, the poller issues a stop (`cmd_op` = 2'b11) and then a new probe, as long as fewer than `MAX_PROBES` probes have been sent.
- R5: When the engine reports `eng_nack` = 0 for a probe byte, `ready` rises and no stop or any other command is issued. `probe_count` then equals the number of probes sent, and `ready` and `timeout_err` are never high together.
- R6: If `MAX_PROBES` consecutive probes are refused, the poller issues the stop for the last one, raises `timeout_err` with `probe_count` = `MAX_PROBES`, and issues no further command.
- R7: `ready` and `timeout_err` hold until the next accepted `go`. A `go` while `busy` is high is ignored, and so is its `dev_addr`.
- R8: A `go` accepted while idle or finished drives the first start command in the very next cycle. It clears `probe_count` and latches `dev_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start polling; accepted when `busy` is 0 |
| dev_addr | input | ADDR_W | Target device address, latched on an accepted `go` |
| cmd_valid | output | 1 | One-cycle command strobe to the byte engine |
| cmd_op | output | 2 | 01 start, 10 send byte, 11 stop |
| cmd_byte | output | ADDR_W+1 | Byte to send; {address, 0} on a send |
| eng_done | input | 1 | Engine has finished the last command |
| eng_nack | input | 1 | Acknowledge bit of the last sent byte (1 = refused) |
| busy | output | 1 | Probe loop running |
| ready | output | 1 | Target acknowledged; next operation may proceed |
| timeout_err | output | 1 | Probe limit reached without an acknowledge |
| probe_count | output | CNT_W | Probes sent since the last accepted `go` |

## Verification
A modelled engine refuses the first K probes and then acknowledges. K is swept from zero past the probe limit, so the sweep separates an immediate acknowledge, acknowledges just before and at the last allowed probe, and the timeout case. Each value of K is run with several engine response latencies and device addresses. This shows that the command count and order depend only on K, while the address reaches the right bits regardless of latency. One run sends a second `go` with a different address in mid-loop, which tells a correctly ignored request apart from one that restarts the loop or swaps the address.

// File: rtl/ack_poll_pkg.sv
// Shared types for the acknowledge poller: engine operation codes and
// controller states. Assumes a 2-bit command field at the engine.
package ack_poll_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_START = 2'b01,
        OP_WRITE = 2'b10,
        OP_STOP  = 2'b11
    } eng_op_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START_ISS,
        S_START_WT,
        S_ADDR_ISS,
        S_ADDR_WT,
        S_STOP_ISS,
        S_STOP_WT,
        S_DONE_OK,
        S_DONE_ERR
    } poll_state_t;
endpackage

// File: rtl/ack_poll_counter.sv
// Probe counter: counts probes sent since the last clear and flags the
// configured limit. Assumes inc is never raised once the limit is reached.
module ack_poll_counter #(
    parameter int MAX_PROBES = 8,
    parameter int CNT_W      = $clog2(MAX_PROBES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             at_limit
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_PROBES);

    // Count probes; clear has priority over increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc && cnt != LIMIT)
            cnt <= cnt + 1'b1;
    end

    // Limit flag for the sequencer.
    always_comb at_limit = (cnt == LIMIT);
endmodule

// File: rtl/ack_poll_addr_latch.sv
// Address latch and byte former: captures the device address on load and
// forms the control byte with the write direction bit at bit 0.
module ack_poll_addr_latch #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              send_sel,
    output logic [ADDR_W:0]   byte_out
);
    logic [ADDR_W-1:0] addr_q;

    // Hold the address of the current polling run.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (load)
            addr_q <= addr_in;
    end

    // Control byte only on a send command; zero otherwise.
    always_comb byte_out = send_sel ? {addr_q, 1'b0} : '0;
endmodule

// File: rtl/ack_poll_fsm.sv
// Probe-loop sequencer: issues start / send / stop commands one at a time,
// waiting for the engine's done pulse after each. Assumes eng_nack is valid
// in the cycle eng_done is high.
module ack_poll_fsm
    import ack_poll_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    go,
    input  logic    eng_done,
    input  logic    eng_nack,
    input  logic    at_limit,
    output logic    cmd_valid,
    output eng_op_t cmd_op,
    output logic    cnt_clr,
    output logic    cnt_inc,
    output logic    busy,
    output logic    ready,
    output logic    timeout_err
);
    poll_state_t st, nxt;
    logic        accept;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= S_IDLE;
        else
            st <= nxt;
    end

    // Next-state logic of the probe loop.
    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE, S_DONE_OK, S_DONE_ERR: if (go) nxt = S_START_ISS;
            S_START_ISS: nxt = S_START_WT;
            S_START_WT:  if (eng_done) nxt = S_ADDR_ISS;
            S_ADDR_ISS:  nxt = S_ADDR_WT;
            S_ADDR_WT:   if (eng_done) nxt = eng_nack ? S_STOP_ISS : S_DONE_OK;
            S_STOP_ISS:  nxt = S_STOP_WT;
            S_STOP_WT:   if (eng_done) nxt = at_limit ? S_DONE_ERR : S_START_ISS;
            default:     nxt = S_IDLE;
        endcase
    end

    // Status and command decode from the current state.
    always_comb begin
        busy        = !(st == S_IDLE || st == S_DONE_OK || st == S_DONE_ERR);
        ready       = (st == S_DONE_OK);
        timeout_err = (st == S_DONE_ERR);
        accept      = go && !busy;
        cnt_clr     = accept;
        cnt_inc     = (st == S_ADDR_ISS);
        cmd_valid   = (st == S_START_ISS) || (st == S_ADDR_ISS) || (st == S_STOP_ISS);
        unique case (st)
            S_START_ISS: cmd_op = OP_START;
            S_ADDR_ISS:  cmd_op = OP_WRITE;
            S_STOP_ISS:  cmd_op = OP_STOP;
            default:     cmd_op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/ack_poll_ctrl.sv
// Top of the acknowledge poller: waits for a memory write cycle to end by
// probing the device address until it is acknowledged or a limit is hit.
// Assumes a byte engine that answers each command with a one-cycle done.
module ack_poll_ctrl
    import ack_poll_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int MAX_PROBES = 8,
    parameter int CNT_W      = $clog2(MAX_PROBES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] dev_addr,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [ADDR_W:0]   cmd_byte,
    input  logic              eng_done,
    input  logic              eng_nack,
    output logic              busy,
    output logic              ready,
    output logic              timeout_err,
    output logic [CNT_W-1:0]  probe_count
);
    eng_op_t op_w;
    logic    cnt_clr, cnt_inc, at_limit;

    ack_poll_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .go(go),
        .eng_done(eng_done), .eng_nack(eng_nack), .at_limit(at_limit),
        .cmd_valid(cmd_valid), .cmd_op(op_w),
        .cnt_clr(cnt_clr), .cnt_inc(cnt_inc),
        .busy(busy), .ready(ready), .timeout_err(timeout_err)
    );

    ack_poll_counter #(.MAX_PROBES(MAX_PROBES), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
        .cnt(probe_count), .at_limit(at_limit)
    );

    ack_poll_addr_latch #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(cnt_clr), .addr_in(dev_addr),
        .send_sel(op_w == OP_WRITE), .byte_out(cmd_byte)
    );

    // Operation code to the port.
    always_comb cmd_op = op_w;
endmodule

// File: rtl/ack_poll_ctrl_sva.sv
// Checker for the acknowledge poller, bound to every instance of the top.
module ack_poll_ctrl_sva #(
    parameter int ADDR_W     = 7,
    parameter int MAX_PROBES = 8,
    parameter int CNT_W      = $clog2(MAX_PROBES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              go,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic [ADDR_W:0]   cmd_byte,
    input logic              busy,
    input logic              ready,
    input logic              timeout_err,
    input logic [CNT_W-1:0]  probe_count
);
    assert_idle_out_of_reset_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!busy && !ready && !timeout_err && !cmd_valid && probe_count == '0));

    assert_send_dir_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b10) |-> (cmd_byte[0] == 1'b0));

    assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    assert_quiet_when_finished_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready || timeout_err) |-> !cmd_valid);

    assert_status_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && timeout_err));

    assert_err_at_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> (probe_count == CNT_W'(MAX_PROBES)));

    assert_ready_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !go) |=> ready);

    assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_err && !go) |=> timeout_err);

    assert_prompt_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy) |=> (cmd_valid && cmd_op == 2'b01));
endmodule

bind ack_poll_ctrl ack_poll_ctrl_sva #(
    .ADDR_W(ADDR_W), .MAX_PROBES(MAX_PROBES), .CNT_W(CNT_W)
) u_sva (
    .clk(clk), .rst_n(rst_n), .go(go), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .busy(busy), .ready(ready), .timeout_err(timeout_err),
    .probe_count(probe_count)
);

// File: tb/ack_poll_ctrl_tb_top.sv
// Sweep bench: a modelled byte engine refuses the first K probes, then acks.
module ack_poll_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 7;
    localparam int MAXP       = 4;
    localparam int CNT_W      = $clog2(MAXP + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              go = 1'b0;
    logic [ADDR_W-1:0] dev_addr = '0;
    logic              cmd_valid;
    logic [1:0]        cmd_op;
    logic [ADDR_W:0]   cmd_byte;
    logic              eng_done, eng_nack;
    logic              busy, ready, timeout_err;
    logic [CNT_W-1:0]  probe_count;

    always #(CLK_PERIOD/2) clk = ~clk;

    ack_poll_ctrl #(.ADDR_W(ADDR_W), .MAX_PROBES(MAXP)) dut_i (
        .clk(clk), .rst_n(rst_n), .go(go), .dev_addr(dev_addr),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
        .eng_done(eng_done), .eng_nack(eng_nack),
        .busy(busy), .ready(ready), .timeout_err(timeout_err),
        .probe_count(probe_count)
    );

    // Engine model configuration, driven by the stimulus process.
    int          cfg_lat = 0;
    int          cfg_k   = 0;
    logic [7:0]  exp_byte = '0;
    logic        clr = 1'b0;

    // Engine model state and logs.
    logic        pending = 1'b0;
    int          tmr = 0;
    logic        cur_nack = 1'b0;
    int          n_start = 0, n_write = 0, n_stop = 0, n_bad_byte = 0;
    int          n_overlap = 0, n_order = 0;
    logic [1:0]  last_op = 2'b00;

    initial begin
        eng_done = 1'b0;
        eng_nack = 1'b0;
    end

    // Byte engine model: answers each command after cfg_lat extra cycles.
    always @(posedge clk) begin
        eng_done <= 1'b0;
        if (clr) begin
            pending <= 1'b0; n_start <= 0; n_write <= 0; n_stop <= 0;
            n_bad_byte <= 0; n_overlap <= 0; n_order <= 0; last_op <= 2'b11;
        end else begin
            if (pending) begin
                if (tmr == 0) begin
                    eng_done <= 1'b1;
                    eng_nack <= cur_nack;
                    pending  <= 1'b0;
                end else begin
                    tmr <= tmr - 1;
                end
            end
            if (cmd_valid) begin
                if (pending) n_overlap <= n_overlap + 1;
                pending <= 1'b1;
                tmr     <= cfg_lat;
                last_op <= cmd_op;
                cur_nack <= 1'b0;
                case (cmd_op)
                    2'b01: begin
                        n_start <= n_start + 1;
                        if (last_op != 2'b11) n_order <= n_order + 1;
                    end
                    2'b10: begin
                        n_write <= n_write + 1;
                        cur_nack <= (n_write < cfg_k);
                        if (cmd_byte != exp_byte) n_bad_byte <= n_bad_byte + 1;
                        if (last_op != 2'b01) n_order <= n_order + 1;
                    end
                    2'b11: begin
                        n_stop <= n_stop + 1;
                        if (last_op != 2'b10) n_order <= n_order + 1;
                    end
                    default: n_order <= n_order + 1;
                endcase
            end
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (k=%0d lat=%0d)", req, act, exp, cfg_k, cfg_lat);
        end
    endtask

    // Watchdog: an expired run counts as a failure and still summarises.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // One polling run with k refusals, latency lat and address a.
    task automatic run(input int k, input int lat, input logic [ADDR_W-1:0] a, input bit interfere);
        int exp_probes, exp_stops, waited;
        bit exp_ok;
        int stops_at_end;
        @(negedge clk);
        clr = 1'b1; cfg_k = k; cfg_lat = lat; exp_byte = {a, 1'b0};
        @(negedge clk);
        clr = 1'b0;
        go = 1'b1; dev_addr = a;
        @(negedge clk);
        go = 1'b0; dev_addr = ~a;
        // R8: start command right after the accepted go, count cleared.
        check(cmd_valid && cmd_op == 2'b01, "R8", {30'd0, cmd_op}, 1);
        check(probe_count == 0, "R8", probe_count, 0);
        if (interfere) begin
            repeat (3) @(negedge clk);
            go = 1'b1; dev_addr = a ^ 7'h55;
            @(negedge clk);
            go = 1'b0;
        end
        waited = 0;
        while (!(ready || timeout_err) && waited < 1000) begin
            @(negedge clk);
            waited++;
        end
        exp_ok     = (k < MAXP);
        exp_probes = exp_ok ? k + 1 : MAXP;
        exp_stops  = exp_ok ? k : MAXP;
        stops_at_end = n_stop;
        repeat (8) @(negedge clk);
        check(ready == exp_ok, "R5", ready, exp_ok);
        check(timeout_err == !exp_ok, "R6", timeout_err, !exp_ok);
        check(probe_count == exp_probes, exp_ok ? "R5" : "R6", probe_count, exp_probes);
        check(n_start == exp_probes && n_write == exp_probes, "R2", n_start, exp_probes);
        check(n_bad_byte == 0, interfere ? "R7" : "R2", n_bad_byte, 0);
        check(n_stop == exp_stops, "R4", n_stop, exp_stops);
        check(n_stop == stops_at_end, exp_ok ? "R5" : "R6", n_stop, stops_at_end);
        check(n_overlap == 0, "R3", n_overlap, 0);
        check(n_order == 0, "R4", n_order, 0);
        check(!busy && !cmd_valid, "R7", busy, 0);
    endtask

    initial begin
        logic [ADDR_W-1:0] addrs [4];
        addrs[0] = 7'h50; addrs[1] = 7'h7F; addrs[2] = 7'h00; addrs[3] = 7'h2A;
        repeat (3) @(negedge clk);
        // R1: reset state.
        check(!busy && !ready && !timeout_err && !cmd_valid && probe_count == 0, "R1", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !ready && !timeout_err && !cmd_valid && probe_count == 0, "R1", ready, 0);
        for (int ai = 0; ai < 4; ai++)
            for (int lat = 0; lat < 3; lat++)
                for (int k = 0; k <= MAXP + 1; k++)
                    run(k, lat, addrs[ai], 1'b0);
        // R7: a go with a new address during the loop is ignored.
        run(2, 2, 7'h33, 1'b1);
        run(MAXP, 1, 7'h0C, 1'b1);
        // R1: reset from a finished state.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(!ready && !timeout_err && probe_count == 0, "R1", probe_count, 0);
        rst_n = 1'b1;
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule